// File: doc/BRIEF.md
# Execution Tag Allocator

This block issues and recovers the 6-bit tags used by a Tomasulo-style out-of-order scheduler. Each tag names one in-flight operation. The two high bits pick the execution class and the four low bits number the tag within that class. The decode stage presents the needs of one instruction per cycle as three request bits, one each for an ALU, multiplier or memory tag. The block grants every requested tag in the same cycle, or it grants none and raises a stall.

Results come back on up to three completion buses. Each bus carries a valid bit and a tag. Every tag named by a valid bus returns to its pool and can be handed out again from the following cycle. Each reservation station has exactly as many slots as its class has tags, so the per-class free counts also report how much room each station has left.

Top module: `tag_alloc`

## Requirements
- R1: A tag is 6 bits. Bits [5:4] give the class: 00 and 11 are ALU, 01 is multiplier, 10 is memory. Bits [3:0] are the index within that prefix.
- R2: After reset every tag is free. The counts read 32 (ALU), 16 (multiplier) and 16 (memory), and stall is low.
- R3: Within each pool the free tag with the lowest index is granted first. The ALU pool takes all prefix-00 tags (index 0 to 15) before any prefix-11 tag.
- R4: A cycle's request is all-or-nothing. A memory instruction that raises need_alu and need_mem together receives one ALU tag and one memory tag in the same cycle.
- R5: If any requested class has no free tag, grant is low and stall is high, and no tag of any class is consumed.
- R6: A granted tag is not granted again until a completion bus returns it.
- R7: A valid completion bus frees its tag at the next clock edge. Up to three tags of any classes can be freed in one cycle. A freed tag is not available to a request in the same cycle that frees it.
- R8: free_alu, free_mul and free_mem always equal the number of free tags in each pool.
- R9: With no request bit set, grant and stall are low and no tag is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| need_alu | input | 1 | Instruction needs an ALU tag |
| need_mul | input | 1 | Instruction needs a multiplier tag |
| need_mem | input | 1 | Instruction needs a memory tag |
| cmp_valid | input | 3 | Valid bit for each completion bus |
| cmp_tag | input | 18 | Completion tags; bus k is at bits [6k+5:6k] |
| grant | output | 1 | All requested tags are issued this cycle |
| stall | output | 1 | Request cannot be fully served |
| alu_tag | output | 6 | Granted ALU tag (meaningful with grant) |
| mul_tag | output | 6 | Granted multiplier tag (meaningful with grant) |
| mem_tag | output | 6 | Granted memory tag (meaningful with grant) |
| free_alu | output | 6 | Free ALU tags |
| free_mul | output | 5 | Free multiplier tags |
| free_mem | output | 5 | Free memory tags |

## Verification
The assertions check on every cycle that grant and stall never both hold and that a pool never hands out a tag while empty. They also check that a granted tag leaves the free set at the next edge, and that a stalled cycle with no completions leaves every count unchanged. Other properties can only be shown by the bench's scenarios. These are the exact grant order across both ALU prefixes, the atomic refusal of a two-tag memory request, the one-cycle delay before a returned tag can be reused, and release through each of the three buses.

// File: rtl/tag_alloc_pkg.sv
package tag_alloc_pkg;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU_LO = 2'b00,
    CLS_MUL    = 2'b01,
    CLS_MEM    = 2'b10,
    CLS_ALU_HI = 2'b11
  } tag_cls_e;
endpackage

// File: rtl/tag_pool.sv
module tag_pool #(
  parameter int N = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic [N-1:0]               rel_vec,
  output logic                       avail,
  output logic [$clog2(N)-1:0]       pick,
  output logic [$clog2(N+1)-1:0]     free_cnt
);
  localparam int IDX_W = $clog2(N);
  localparam int CNT_W = $clog2(N+1);

  logic [N-1:0] free_q;
  logic [N-1:0] free_d;
  logic [N-1:0] take_vec;
  logic         upd_en;

  // lowest free index wins
  always_comb begin
    pick  = '0;
    avail = |free_q;
    for (int i = N-1; i >= 0; i--) begin
      if (free_q[i]) pick = IDX_W'(i);
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      take_vec[i] = take && (pick == IDX_W'(i));
    end
    free_d = (free_q | rel_vec) & ~take_vec;
    upd_en = take | (|rel_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '1;
    end else if (upd_en) begin
      free_q <= free_d;
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < N; i++) begin
      free_cnt = free_cnt + CNT_W'(free_q[i]);
    end
  end

  // R5
  take_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> avail);

  // R6
  alloc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !free_q[$past(pick)]);
endmodule

// File: rtl/tag_release_decode.sv
module tag_release_decode #(
  parameter int ID_W    = 4,
  parameter int NUM_BUS = 3
) (
  input  logic [NUM_BUS-1:0]           cmp_valid,
  input  logic [NUM_BUS*(ID_W+2)-1:0]  cmp_tag,
  output logic [2*(1<<ID_W)-1:0]       rel_alu,
  output logic [(1<<ID_W)-1:0]         rel_mul,
  output logic [(1<<ID_W)-1:0]         rel_mem
);
  import tag_alloc_pkg::*;
  localparam int TAG_W = ID_W + 2;
  localparam int POOL  = 1 << ID_W;

  logic [TAG_W-1:0] t;
  logic [ID_W-1:0]  id;

  always_comb begin
    rel_alu = '0;
    rel_mul = '0;
    rel_mem = '0;
    t  = '0;
    id = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      t  = cmp_tag[b*TAG_W +: TAG_W];
      id = t[ID_W-1:0];
      if (cmp_valid[b]) begin
        case (tag_cls_e'(t[TAG_W-1 -: CLS_W]))
          CLS_ALU_LO: rel_alu[id]                   = 1'b1;
          CLS_ALU_HI: rel_alu[POOL + int'(id)]      = 1'b1;
          CLS_MUL:    rel_mul[id]                   = 1'b1;
          default:    rel_mem[id]                   = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/tag_alloc.sv
module tag_alloc #(
  parameter int ID_W    = 4,
  parameter int NUM_BUS = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  need_alu,
  input  logic                                  need_mul,
  input  logic                                  need_mem,
  input  logic [NUM_BUS-1:0]                    cmp_valid,
  input  logic [NUM_BUS*(ID_W+2)-1:0]           cmp_tag,
  output logic                                  grant,
  output logic                                  stall,
  output logic [ID_W+1:0]                       alu_tag,
  output logic [ID_W+1:0]                       mul_tag,
  output logic [ID_W+1:0]                       mem_tag,
  output logic [$clog2(2*(1<<ID_W)+1)-1:0]      free_alu,
  output logic [$clog2((1<<ID_W)+1)-1:0]        free_mul,
  output logic [$clog2((1<<ID_W)+1)-1:0]        free_mem
);
  import tag_alloc_pkg::*;
  localparam int POOL     = 1 << ID_W;
  localparam int ALU_POOL = 2 * POOL;

  logic [ALU_POOL-1:0] rel_alu;
  logic [POOL-1:0]     rel_mul;
  logic [POOL-1:0]     rel_mem;

  logic alu_avail, mul_avail, mem_avail;
  logic [ID_W:0]   alu_pick;
  logic [ID_W-1:0] mul_pick, mem_pick;
  logic any_need, fits;

  tag_release_decode #(.ID_W(ID_W), .NUM_BUS(NUM_BUS)) u_rel (
    .cmp_valid (cmp_valid),
    .cmp_tag   (cmp_tag),
    .rel_alu   (rel_alu),
    .rel_mul   (rel_mul),
    .rel_mem   (rel_mem)
  );

  always_comb begin
    any_need = need_alu | need_mul | need_mem;
    fits     = (alu_avail | ~need_alu) & (mul_avail | ~need_mul) &
               (mem_avail | ~need_mem);
    grant    = any_need & fits;
    stall    = any_need & ~fits;
  end

  tag_pool #(.N(ALU_POOL)) u_alu (
    .clk (clk), .rst_n (rst_n), .take (grant & need_alu), .rel_vec (rel_alu),
    .avail (alu_avail), .pick (alu_pick), .free_cnt (free_alu)
  );
  tag_pool #(.N(POOL)) u_mul (
    .clk (clk), .rst_n (rst_n), .take (grant & need_mul), .rel_vec (rel_mul),
    .avail (mul_avail), .pick (mul_pick), .free_cnt (free_mul)
  );
  tag_pool #(.N(POOL)) u_mem (
    .clk (clk), .rst_n (rst_n), .take (grant & need_mem), .rel_vec (rel_mem),
    .avail (mem_avail), .pick (mem_pick), .free_cnt (free_mem)
  );

  always_comb begin
    alu_tag = {(alu_pick[ID_W] ? CLS_ALU_HI : CLS_ALU_LO), alu_pick[ID_W-1:0]};
    mul_tag = {CLS_MUL, mul_pick};
    mem_tag = {CLS_MEM, mem_pick};
  end

  // R5
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && stall));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && cmp_valid == '0) |=>
      ($stable(free_alu) && $stable(free_mul) && $stable(free_mem)));

  // R8
  mul_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && need_mul && cmp_valid == '0) |=> (free_mul == $past(free_mul) - 1'b1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!need_alu && !need_mul && !need_mem && cmp_valid == '0) |=> $stable(free_alu));
endmodule

// File: tb/tag_alloc_bench.sv
module tag_alloc_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic need_alu, need_mul, need_mem;
  logic [2:0]  cmp_valid;
  logic [17:0] cmp_tag;
  logic grant, stall;
  logic [5:0] alu_tag, mul_tag, mem_tag;
  logic [5:0] free_alu;
  logic [4:0] free_mul, free_mem;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tag_alloc u_tag_alloc (
    .clk (clk), .rst_n (rst_n),
    .need_alu (need_alu), .need_mul (need_mul), .need_mem (need_mem),
    .cmp_valid (cmp_valid), .cmp_tag (cmp_tag),
    .grant (grant), .stall (stall),
    .alu_tag (alu_tag), .mul_tag (mul_tag), .mem_tag (mem_tag),
    .free_alu (free_alu), .free_mul (free_mul), .free_mem (free_mem)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic a, input logic m, input logic e);
    need_alu = a; need_mul = m; need_mem = e;
    #1;
  endtask

  task automatic edge_step();
    @(posedge clk);
    @(negedge clk);
    need_alu = 0; need_mul = 0; need_mem = 0;
    cmp_valid = '0; cmp_tag = '0;
  endtask

  initial begin
    need_alu = 0; need_mul = 0; need_mem = 0;
    cmp_valid = '0; cmp_tag = '0;
    rst_n = 0;
    #45;
    @(negedge clk);
    rst_n = 1;
    #1;
    // R2 / R9
    chk(free_alu, 32, "R2 alu count");
    chk(free_mul, 16, "R2 mul count");
    chk(free_mem, 16, "R2 mem count");
    chk(stall, 0, "R2 stall");
    chk(grant, 0, "R9 idle grant");
    edge_step();
    chk(free_alu, 32, "R9 idle keeps count");

    // R1 / R3 / R6 / R8: sweep whole ALU pool
    for (int i = 0; i < 32; i++) begin
      setup(1, 0, 0);
      chk(grant, 1, "R3 alu grant");
      chk(alu_tag, (i < 16) ? i : 48 + (i - 16), "R1 R3 R6 alu tag order");
      chk(free_alu, 32 - i, "R8 alu count");
      edge_step();
    end
    setup(1, 0, 0);
    chk(stall, 1, "R5 alu empty stall");
    chk(grant, 0, "R5 alu empty grant");
    edge_step();
    // R4: memory instruction needs ALU and MEM atomically
    setup(1, 0, 1);
    chk(stall, 1, "R4 mem instr stalls");
    edge_step();
    chk(free_mem, 16, "R4 mem tag not consumed");

    // R7: release 0x35 on bus 2 while requesting
    cmp_valid = 3'b100; cmp_tag = {6'h35, 12'h0};
    setup(1, 0, 0);
    chk(stall, 1, "R7 same-cycle reuse blocked");
    edge_step();
    chk(free_alu, 1, "R7 freed count");
    setup(1, 0, 0);
    chk(alu_tag, 'h35, "R7 reuse tag");
    edge_step();

    // R7: three buses in one cycle
    cmp_valid = 3'b111; cmp_tag = {6'h3F, 6'h0F, 6'h00};
    #1;
    edge_step();
    chk(free_alu, 3, "R7 triple release");
    setup(1, 0, 1);
    chk(grant, 1, "R4 dual grant");
    chk(alu_tag, 'h00, "R4 alu part");
    chk(mem_tag, 'h20, "R1 R4 mem part");
    edge_step();
    chk(free_alu, 2, "R4 alu consumed");
    chk(free_mem, 15, "R4 mem consumed");

    // multiplier sweep
    for (int i = 0; i < 16; i++) begin
      setup(0, 1, 0);
      chk(mul_tag, 16 + i, "R1 R3 mul tag order");
      edge_step();
    end
    setup(0, 1, 1);
    chk(stall, 1, "R5 mul empty stall");
    edge_step();
    chk(free_mem, 15, "R5 mem untouched");
    // return each mul tag, rotating over buses
    for (int i = 0; i < 16; i++) begin
      cmp_valid = 3'(1 << (i % 3));
      cmp_tag = 18'(6'(16 + i)) << (6 * (i % 3));
      #1;
      edge_step();
      chk(free_mul, i + 1, "R7 R8 mul release via bus");
    end
    setup(0, 1, 0);
    chk(mul_tag, 'h10, "R3 lowest after refill");
    edge_step();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule